// File: doc/BRIEF.md
# Multi-Channel Capture/Compare PWM Array

This block gives a set of identical channels one shared 16-bit up-counter. The counter advances on each clock cycle in which its clock-enable input is high. Each channel owns a 16-bit compare/capture register and one output pin. A channel can be set to one of five roles:

- timestamping edges on its input pin;
- raising a flag when the counter reaches a value;
- toggling its pin at a counter match;
- producing a square wave whose half-period is programmable;
- generating PWM of 8, 9, 10, 11 or 16 bits, either edge-aligned or centred on the period boundary.

A per-channel polarity bit inverts the pin. A kill input, which acts without waiting for a clock, drives every PWM pin to its inactive level. Software reaches the block through a word-wide register write port and a combinational read port. Channel and overflow events land in sticky flags, which are cleared by writing ones.

Top module: `cc_pwm_array`

## Requirements
- R1: The counter increments by one on every clock edge at which `tick_en` is high and holds otherwise. A write to address 0 loads it, and the write takes precedence over a tick in the same cycle.
- R2: A tick while the counter is 0xFFFF wraps it to 0 and sets the overflow flag. The overflow flag is bit 0 of address 1.
- R3: In capture mode (mode 1), the channel input passes through two synchroniser stages. A qualifying edge then copies the counter into the channel register and sets the channel flag. Config bit 3 enables rising edges and bit 4 enables falling edges; both bits set captures either edge, and neither bit set captures nothing.
- R4: In software-timer mode (mode 2), a tick while the counter equals the channel register sets the channel flag and leaves the pin unchanged.
- R5: In toggle-on-match mode (mode 3), the same match condition toggles the pin and sets the flag.
- R6: In frequency mode (mode 4), the register's high byte is a step and its low byte is the next target. On a tick where the counter's low byte equals the target, the pin toggles, the step is added to the target modulo 256, and the flag is set.
- R7: In PWM mode (mode 5), config bits [7:5] choose the resolution N: values 0 to 3 give 8 to 11 bits, and 4 to 7 give 16 bits. With edge alignment, the raw output is high while the counter's low N bits are below the register's low N bits. Register bits above N are ignored.
- R8: With config bit 8 set (centre alignment), the phase is the counter's low N bits. It is mirrored when its top bit is set. The raw output is high while twice the mirrored phase is below the register's low N bits, which centres the pulse on the period boundary.
- R9: In PWM mode, a register write only updates the shadow, which is read at address 12+ch. The active value, read at address 8+ch, takes the shadow on the tick at which the counter's low N bits are all ones. Outside PWM mode, a write updates both.
- R10: Config bit 9 inverts the channel pin.
- R11: While `kill` is high, every channel in PWM mode drives its pin to the value of its polarity bit, with no clock delay. Pins of channels in other modes are unaffected.
- R12: Writing address 1 clears each flag whose data bit is 1 and leaves the others set. A new event in the same cycle wins over the clear. Channel flags sit at bits 1 to NCH.
- R13: Configuration words sit at address 4+ch, with the mode in bits [2:0]: 0 off, 1 capture, 2 software timer, 3 toggle, 4 frequency, 5 PWM. Config bits [15:10] read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Counter advance enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| cap_in | input | NCH | Channel input pins |
| kill | input | 1 | Asynchronous PWM kill |
| pin_out | output | NCH | Channel output pins |
| ovf_flag | output | 1 | Counter overflow flag |
| ch_flag | output | NCH | Channel event flags |

## Verification
The bench uses the default build of three channels with a 16-bit counter. This allows capture, toggle and frequency roles to run on separate channels at the same time as a PWM channel, so the kill input can be seen leaving non-PWM pins alone. Preloading the counter brings wrap and match points within a few cycles. The 8-bit and 10-bit PWM periods are short enough that whole periods can be counted. This makes the exact duty, the inverted duty and the centre-aligned shape observable from the pins.

// File: rtl/cc_pwm_pkg.sv
// Shared types for the capture/compare PWM array.
// Assumes a 16-bit register word; the configuration word layout is fixed here.
package cc_pwm_pkg;

    typedef enum logic [2:0] {
        M_OFF = 3'd0,
        M_CAP = 3'd1,
        M_SWT = 3'd2,
        M_HSO = 3'd3,
        M_FRQ = 3'd4,
        M_PWM = 3'd5
    } cc_mode_e;

    typedef struct packed {
        logic [5:0] rsv;
        logic       inv;
        logic       center;
        logic [2:0] res;
        logic [1:0] edge_sel;
        cc_mode_e   mode;
    } cc_cfg_t;

    localparam logic [15:0] CFG_MASK = 16'h03FF;

    // Period mask for a resolution code.
    function automatic logic [15:0] res_mask(input logic [2:0] res);
        case (res)
            3'd0:    return 16'h00FF;
            3'd1:    return 16'h01FF;
            3'd2:    return 16'h03FF;
            3'd3:    return 16'h07FF;
            default: return 16'hFFFF;
        endcase
    endfunction

endpackage

// File: rtl/cc_pwm_timebase.sv
// Shared up-counter with load and a sticky overflow flag.
// Assumes CNT_W matches the register word width (16).
module cc_pwm_timebase #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             ovf_clr,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic wrap;
    assign wrap = tick && !cnt_we && (cnt == CNT_MAX);

    // Counter: load wins, otherwise advance on tick.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (cnt_we) cnt <= cnt_wdata;
        else if (tick)   cnt <= cnt + 1'b1;
    end

    // Overflow flag: set on wrap, cleared by write-one.
    always_ff @(posedge clk) begin
        if (!rst_n)       ovf <= 1'b0;
        else if (wrap)    ovf <= 1'b1;
        else if (ovf_clr) ovf <= 1'b0;
    end

    p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_we) |=> (cnt == $past(cnt) + 1'b1));
    p_count_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_we) |=> $stable(cnt));
    p_ovf_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_we && cnt == CNT_MAX) |=> ovf);

endmodule

// File: rtl/cc_pwm_channel.sv
// One capture/compare channel: configuration, active and shadow registers,
// input synchroniser, event flag and output pin.
// Assumes the counter is 16 bits; the frequency mode works on its low byte.
module cc_pwm_channel
    import cc_pwm_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt,
    input  logic             cap_raw,
    input  logic             kill,
    input  logic             cfg_we,
    input  logic             ccr_we,
    input  logic [CNT_W-1:0] wdata,
    input  logic             flag_clr,
    output cc_cfg_t          cfg_q,
    output logic [CNT_W-1:0] ccr_q,
    output logic [CNT_W-1:0] shd_q,
    output logic             flag_q,
    output logic             pin
);
    localparam int SH_W = SYNC_N + 1;

    logic [SH_W-1:0]  sync_q;
    logic             out_q;
    logic [CNT_W-1:0] mask, phase, half, mirr, ccr_m;
    logic             rise, fall, cap_hit, cmp_hit, frq_hit, wrap_hit;
    logic             edge_act, ctr_act, pwm_raw, raw, event_hit;

    // Event decode from the counter and synchronised input.
    always_comb begin
        mask     = res_mask(cfg_q.res);
        phase    = cnt & mask;
        half     = (mask >> 1) + 1'b1;
        mirr     = ((phase & half) != '0) ? (mask - phase) : phase;
        ccr_m    = ccr_q & mask;
        edge_act = phase < ccr_m;
        ctr_act  = {mirr[CNT_W-2:0], 1'b0} < ccr_m;
        pwm_raw  = cfg_q.center ? ctr_act : edge_act;
        rise     = sync_q[SH_W-2] & ~sync_q[SH_W-1];
        fall     = ~sync_q[SH_W-2] & sync_q[SH_W-1];
        cap_hit  = (cfg_q.edge_sel[0] & rise) | (cfg_q.edge_sel[1] & fall);
        cmp_hit  = tick && (cnt == ccr_q);
        frq_hit  = tick && (cnt[7:0] == ccr_q[7:0]);
        wrap_hit = tick && (phase == mask);
        unique case (cfg_q.mode)
            M_CAP:        event_hit = cap_hit;
            M_SWT, M_HSO: event_hit = cmp_hit;
            M_FRQ:        event_hit = frq_hit;
            M_PWM:        event_hit = wrap_hit;
            default:      event_hit = 1'b0;
        endcase
    end

    // Input synchroniser plus one stage of edge history.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SH_W-2:0], cap_raw};
    end

    // Configuration word with reserved bits forced to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_we) cfg_q <= cc_cfg_t'(wdata & CFG_MASK);
    end

    // Shadow register: every write lands here.
    always_ff @(posedge clk) begin
        if (!rst_n)      shd_q <= '0;
        else if (ccr_we) shd_q <= wdata;
    end

    // Active register: direct write, capture, frequency step or PWM reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ccr_q <= '0;
        end else if (ccr_we && cfg_q.mode != M_PWM) begin
            ccr_q <= wdata;
        end else if (cfg_q.mode == M_CAP && cap_hit) begin
            ccr_q <= cnt;
        end else if (cfg_q.mode == M_FRQ && frq_hit) begin
            ccr_q[7:0] <= ccr_q[7:0] + ccr_q[15:8];
        end else if (cfg_q.mode == M_PWM && wrap_hit) begin
            ccr_q <= shd_q;
        end
    end

    // Toggle state for the match-toggle and frequency roles.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_q <= 1'b0;
        else if ((cfg_q.mode == M_HSO && cmp_hit) || (cfg_q.mode == M_FRQ && frq_hit))
            out_q <= ~out_q;
    end

    // Sticky event flag; a new event wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)         flag_q <= 1'b0;
        else if (event_hit) flag_q <= 1'b1;
        else if (flag_clr)  flag_q <= 1'b0;
    end

    // Pin: polarity applied, kill overrides PWM without a clock.
    assign raw = (cfg_q.mode == M_PWM) ? pwm_raw : out_q;
    assign pin = (kill && cfg_q.mode == M_PWM) ? cfg_q.inv : (raw ^ cfg_q.inv);

    p_cap_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.mode == M_CAP && cap_hit && !ccr_we) |=> (ccr_q == $past(cnt)));
    p_swt_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.mode == M_SWT) |=> $stable(out_q));
    p_hso_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.mode == M_HSO && cmp_hit) |=> (out_q != $past(out_q)));
    p_shadow_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.mode == M_PWM && !wrap_hit) |=> $stable(ccr_q));
    p_kill_safe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (kill && cfg_q.mode == M_PWM) |-> (pin == cfg_q.inv));
    p_flag_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !flag_clr) |=> flag_q);

endmodule

// File: rtl/cc_pwm_array.sv
// Top: shared timebase, NCH channels, register decode and read mux.
// Address map: 0 counter, 1 flags, 4+ch config, 8+ch active, 12+ch shadow.
// Assumes NCH <= 4 and CNT_W = 16 (the register word width).
module cc_pwm_array
    import cc_pwm_pkg::*;
#(
    parameter int NCH   = 3,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             wr_en,
    input  logic [3:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [3:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    input  logic [NCH-1:0]   cap_in,
    input  logic             kill,
    output logic [NCH-1:0]   pin_out,
    output logic             ovf_flag,
    output logic [NCH-1:0]   ch_flag
);
    localparam logic [3:0] A_CNT  = 4'd0;
    localparam logic [3:0] A_FLG  = 4'd1;
    localparam logic [1:0] R_CFG  = 2'd1;
    localparam logic [1:0] R_CCR  = 2'd2;
    localparam logic [1:0] R_SHD  = 2'd3;

    logic [CNT_W-1:0] cnt;
    logic             flg_we;
    cc_cfg_t          cfg_w [NCH];
    logic [CNT_W-1:0] ccr_w [NCH];
    logic [CNT_W-1:0] shd_w [NCH];

    assign flg_we = wr_en && (wr_addr == A_FLG);

    cc_pwm_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_en),
        .cnt_we    (wr_en && (wr_addr == A_CNT)),
        .cnt_wdata (wr_data),
        .ovf_clr   (flg_we && wr_data[0]),
        .cnt       (cnt),
        .ovf       (ovf_flag)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        localparam logic [1:0] IDX = 2'(g);
        cc_pwm_channel #(.CNT_W(CNT_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick_en),
            .cnt      (cnt),
            .cap_raw  (cap_in[g]),
            .kill     (kill),
            .cfg_we   (wr_en && wr_addr == {R_CFG, IDX}),
            .ccr_we   (wr_en && wr_addr == {R_CCR, IDX}),
            .wdata    (wr_data),
            .flag_clr (flg_we && wr_data[g+1]),
            .cfg_q    (cfg_w[g]),
            .ccr_q    (ccr_w[g]),
            .shd_q    (shd_w[g]),
            .flag_q   (ch_flag[g]),
            .pin      (pin_out[g])
        );
    end

    // Read mux over the counter, flags and per-channel words.
    always_comb begin
        rd_data = '0;
        if (rd_addr == A_CNT) begin
            rd_data = cnt;
        end else if (rd_addr == A_FLG) begin
            rd_data = CNT_W'({ch_flag, ovf_flag});
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (rd_addr[1:0] == 2'(i)) begin
                    case (rd_addr[3:2])
                        R_CFG:   rd_data = cfg_w[i];
                        R_CCR:   rd_data = ccr_w[i];
                        R_SHD:   rd_data = shd_w[i];
                        default: rd_data = '0;
                    endcase
                end
            end
        end
    end

    p_flag_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (flg_we && wr_data[0] && !(tick_en && cnt == {CNT_W{1'b1}})) |=> !ovf_flag);

endmodule

// File: tb/cc_pwm_array_test.sv
module cc_pwm_array_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [2:0]  cap_in = '0;
    logic        kill = 1'b0;
    logic [2:0]  pin_out;
    logic        ovf_flag;
    logic [2:0]  ch_flag;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    cc_pwm_array uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .cap_in(cap_in), .kill(kill), .pin_out(pin_out),
        .ovf_flag(ovf_flag), .ch_flag(ch_flag)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output int v);
        rd_addr = a; #1; v = int'(rd_data);
    endtask

    task automatic ticks(input int n);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    // Counts high samples of one pin over n ticking cycles.
    task automatic count_high(input int ch, input int n, output int hi);
        hi = 0;
        tick_en = 1'b1;
        for (int k = 0; k < n; k++) begin
            #1; if (pin_out[ch]) hi++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        int v;
        rd(4'd0, v); chk("R1 reset counter", v, 0);
        rd(4'd1, v); chk("R12 reset flags", v, 0);
        chk("R10 reset pins", int'(pin_out), 0);
    endtask

    task automatic t_counter();
        int v;
        wr(4'd0, 16'h0100);
        ticks(10);
        rd(4'd0, v); chk("R1 count ten ticks", v, 16'h010A);
        repeat (5) @(negedge clk);
        rd(4'd0, v); chk("R1 hold without tick", v, 16'h010A);
    endtask

    task automatic t_overflow();
        int v;
        wr(4'd0, 16'hFFFC);
        ticks(10);
        rd(4'd0, v); chk("R2 wrapped counter", v, 16'h0006);
        repeat (5) @(negedge clk);
        rd(4'd1, v); chk("R2 overflow flag sticky", v & 1, 1);
        wr(4'd1, 16'h0001);
        rd(4'd1, v); chk("R12 overflow cleared", v & 1, 0);
    endtask

    task automatic t_cfg_map();
        int v;
        wr(4'd4, 16'hFC05);
        rd(4'd4, v); chk("R13 reserved bits zero", v, 16'h0005);
        wr(4'd4, 16'h0000);
    endtask

    task automatic t_capture();
        int v;
        wr(4'd5, 16'h0009);                       // ch1 capture, rising
        wr(4'd0, 16'h1234);
        cap_in[1] = 1'b1; repeat (5) @(negedge clk);
        rd(4'd9, v); chk("R3 rising capture value", v, 16'h1234);
        chk("R3 capture flag", int'(ch_flag[1]), 1);
        wr(4'd1, 16'h0004);
        wr(4'd5, 16'h0011);                       // falling only
        wr(4'd0, 16'h2222);
        cap_in[1] = 1'b0; repeat (5) @(negedge clk);
        rd(4'd9, v); chk("R3 falling capture value", v, 16'h2222);
        wr(4'd1, 16'h0004);
        wr(4'd0, 16'h3333);
        cap_in[1] = 1'b1; repeat (5) @(negedge clk);
        rd(4'd9, v); chk("R3 rising ignored when falling selected", v, 16'h2222);
        chk("R3 no flag on ignored edge", int'(ch_flag[1]), 0);
        wr(4'd5, 16'h0019);                       // either edge
        wr(4'd0, 16'h4444);
        cap_in[1] = 1'b0; repeat (5) @(negedge clk);
        rd(4'd9, v); chk("R3 either-edge capture", v, 16'h4444);
        wr(4'd5, 16'h0000);
        wr(4'd1, 16'h0004);
    endtask

    task automatic t_swtimer();
        wr(4'd6, 16'h0002);
        wr(4'd0, 16'h0000);
        wr(4'd10, 16'h0010);
        ticks(40);
        chk("R4 timer flag", int'(ch_flag[2]), 1);
        chk("R4 pin unchanged", int'(pin_out[2]), 0);
        wr(4'd1, 16'h0008);
    endtask

    task automatic t_hso();
        wr(4'd6, 16'h0003);
        wr(4'd0, 16'h0000);
        ticks(40);
        chk("R5 pin toggled", int'(pin_out[2]), 1);
        chk("R5 flag", int'(ch_flag[2]), 1);
        wr(4'd1, 16'h0008);
    endtask

    task automatic t_freq();
        int tog = 0;
        logic prev;
        wr(4'd5, 16'h0004);
        wr(4'd0, 16'h0000);
        wr(4'd9, 16'h0404);
        tick_en = 1'b1;
        repeat (20) @(negedge clk);
        #1; prev = pin_out[1];
        for (int k = 0; k < 64; k++) begin
            @(negedge clk); #1;
            if (pin_out[1] != prev) tog++;
            prev = pin_out[1];
        end
        tick_en = 1'b0;
        chk("R6 toggles in 64 ticks with step 4", tog, 16);
        chk("R6 flag", int'(ch_flag[1]), 1);
        wr(4'd5, 16'h0000);
        wr(4'd1, 16'h0004);
    endtask

    task automatic t_pwm_edge();
        int v, hi;
        wr(4'd4, 16'h0005);
        wr(4'd8, 16'h1F40);
        rd(4'd12, v); chk("R9 shadow written", v, 16'h1F40);
        rd(4'd8, v);  chk("R9 active not yet loaded", v, 0);
        ticks(260);
        rd(4'd8, v);  chk("R9 active loaded at wrap", v, 16'h1F40);
        count_high(0, 256, hi);
        chk("R7 8-bit duty, upper bits ignored", hi, 64);
        wr(4'd4, 16'h0205);
        count_high(0, 256, hi);
        chk("R10 inverted duty", hi, 192);
        tick_en = 1'b0;
    endtask

    task automatic t_kill();
        logic p2;
        wr(4'd4, 16'h0005);
        wr(4'd0, 16'h0000);
        #1; chk("R11 pwm active before kill", int'(pin_out[0]), 1);
        p2 = pin_out[2];
        kill = 1'b1; #1;
        chk("R11 pwm pin forced safe", int'(pin_out[0]), 0);
        chk("R11 non-pwm pin untouched", int'(pin_out[2]), int'(p2));
        wr(4'd4, 16'h0205); #1;
        chk("R11 safe level follows polarity", int'(pin_out[0]), 1);
        wr(4'd4, 16'h0005);
        kill = 1'b0; #1;
        chk("R11 release restores pwm", int'(pin_out[0]), 1);
        @(negedge clk);
    endtask

    task automatic t_res10();
        int hi;
        wr(4'd4, 16'h0045);
        wr(4'd8, 16'h0100);
        ticks(1030);
        count_high(0, 1024, hi);
        tick_en = 1'b0;
        chk("R7 10-bit duty", hi, 256);
    endtask

    task automatic t_center();
        int hi;
        wr(4'd4, 16'h0105);
        wr(4'd8, 16'h0040);
        ticks(260);
        count_high(0, 256, hi);
        tick_en = 1'b0;
        chk("R8 centre duty", hi, 64);
        wr(4'd0, 16'h00FF); #1;
        chk("R8 active at end of period", int'(pin_out[0]), 1);
        wr(4'd0, 16'h0080); #1;
        chk("R8 inactive mid period", int'(pin_out[0]), 0);
        wr(4'd0, 16'h0010); #1;
        chk("R8 active near start", int'(pin_out[0]), 1);
    endtask

    task automatic t_flags();
        int v;
        wr(4'd0, 16'hFFFF);
        ticks(1);
        rd(4'd1, v); chk("R12 overflow and pwm flags set", v & 3, 3);
        wr(4'd1, 16'h0001);
        rd(4'd1, v); chk("R12 only written bit cleared", v & 3, 2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_counter();
        t_overflow();
        t_cfg_map();
        t_capture();
        t_swtimer();
        t_hso();
        t_freq();
        t_pwm_edge();
        t_kill();
        t_res10();
        t_center();
        t_flags();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule